// File: doc/BRIEF.md
# Iterative Shift-Add Multiplier

This block multiplies two 32-bit operands and returns the low 32 bits of the product. It takes a whole operand pair in one request beat and then works through the product one multiplier bit per cycle. On every working cycle the multiplicand moves one place left and the multiplier moves one place right. The multiplicand is added into a running sum only when the multiplier's current bottom bit is set. The low half of a product is the same for unsigned and two's-complement operands, so one datapath serves both.

A three-state controller (idle, computing, holding result) steps the datapath. A modulo counter ends the computing phase after a fixed number of steps, whatever the operand values. Requests and responses each use a valid/ready pair. The block takes a new request only while idle. A finished result stays on the response port until the consumer accepts it.

Top module: `iter_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block is idle: `req_rdy` is 1 and `resp_val` is 0. Asserting reset during a computation returns the block to idle at once.
- R2: `req_rdy` is high only in the idle state and `resp_val` only in the result state, so the two are never high together.
- R3: A request carries operand A in `req_msg[63:32]` and operand B in `req_msg[31:0]`. The response data equals (A × B) mod 2^32.
- R4: Operands read as two's-complement values give the correctly signed low 32 bits of the product (for example −3 × 7 yields 0xFFFFFFEB).
- R5: `resp_val` first rises exactly 33 clock edges after the edge that accepts a request, for every operand pair.
- R6: While `resp_val` is high and `resp_rdy` is low, `resp_val` stays high and `resp_data` does not change.
- R7: A request presented while a computation is running is not accepted (`req_rdy` is low) and does not change the result being produced.
- R8: On the edge where `resp_val` and `resp_rdy` are both high, the block returns to idle: in the next cycle `req_rdy` is 1 and `resp_val` is 0.
- R9: The running sum is cleared when operands are loaded, so no value carries over from an earlier transaction (a zero operand after a nonzero product yields 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_val | input | 1 | Request valid |
| req_rdy | output | 1 | Request ready, high only when idle |
| req_msg | input | 64 | Operand pair: A in bits 63:32, B in bits 31:0 |
| resp_val | output | 1 | Result valid |
| resp_rdy | input | 1 | Consumer ready for the result |
| resp_data | output | 32 | Low 32 bits of the product |

## Verification
The bench uses operands whose products overflow the low word, such as all-ones squared, 2^16 squared and a top-bit operand doubled. A design that kept the wrong half, or that dropped the carry out of the adder, would return a different word for these. It runs a zero operand right after a large product. A design that did not clear the sum on load would return the old value there. It measures the cycles from acceptance to result on every transaction, which shows an off-by-one in the step counter as a latency of 32 or 34. It holds back `resp_rdy` for several cycles and sends a second request while the first is still computing. A design that drops its result early, or that reloads its operands while busy, would corrupt the held answer or accept the second request. A reset asserted during a computation must leave the block ready at once.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;

  // Datapath steering produced by the controller each cycle
  typedef struct packed {
    logic load;  // capture operands, clear running sum
    logic step;  // shift both operand registers
    logic add;   // accumulate the shifted multiplicand
  } mul_ctl_t;

endpackage

// File: rtl/iter_mul_ctrl.sv
module iter_mul_ctrl
  import iter_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_val,
  input  logic     resp_rdy,
  input  logic     b_lsb,
  output logic     req_rdy,
  output logic     resp_val,
  output mul_ctl_t ctl
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEP_LAST = CW'(W);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;
  logic below;

  assign below = (cnt_q != STEP_LAST);

  // next-state decode
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_val)    state_d = ST_CALC;
      ST_CALC: if (!below)     state_d = ST_DONE;
      ST_DONE: if (resp_rdy)   state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  // control outputs
  always_comb begin
    ctl.load = (state_q == ST_IDLE) && req_val;
    ctl.step = (state_q == ST_CALC) && below;
    ctl.add  = ctl.step && b_lsb;
    req_rdy  = (state_q == ST_IDLE);
    resp_val = (state_q == ST_DONE);
  end

  // step counter: cleared on load, advanced on each step
  always_comb begin
    cnt_en = ctl.load || ctl.step;
    cnt_d  = ctl.load ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/iter_mul_dpath.sv
module iter_mul_dpath
  import iter_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mul_ctl_t     ctl,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         b_lsb,
  output logic [W-1:0] sum
);

  logic [W-1:0] mcand_q, mcand_d;
  logic [W-1:0] mplier_q, mplier_d;
  logic [W-1:0] sum_q, sum_d;
  logic         opr_en, sum_en;

  // load-or-shift selection for both operand registers
  always_comb begin
    opr_en   = ctl.load || ctl.step;
    mcand_d  = ctl.load ? op_a : {mcand_q[W-2:0], 1'b0};
    mplier_d = ctl.load ? op_b : {1'b0, mplier_q[W-1:1]};
  end

  // clear-or-accumulate selection for the running sum
  always_comb begin
    sum_en = ctl.load || ctl.add;
    sum_d  = ctl.load ? '0 : sum_q + mcand_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (opr_en) begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  assign b_lsb = mplier_q[0];
  assign sum   = sum_q;

endmodule

// File: rtl/iter_mul.sv
module iter_mul
  import iter_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_val,
  output logic           req_rdy,
  input  logic [2*W-1:0] req_msg,
  output logic           resp_val,
  input  logic           resp_rdy,
  output logic [W-1:0]   resp_data
);

  mul_ctl_t ctl;
  logic     b_lsb;
  logic [W-1:0] op_a, op_b;

  // operand fields: A high half, B low half
  assign op_a = req_msg[2*W-1:W];
  assign op_b = req_msg[W-1:0];

  iter_mul_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_val  (req_val),
    .resp_rdy (resp_rdy),
    .b_lsb    (b_lsb),
    .req_rdy  (req_rdy),
    .resp_val (resp_val),
    .ctl      (ctl)
  );

  iter_mul_dpath #(.W(W)) u_dpath (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .op_a  (op_a),
    .op_b  (op_b),
    .b_lsb (b_lsb),
    .sum   (resp_data)
  );

endmodule

// File: rtl/iter_mul_chk.sv
module iter_mul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_val,
  input logic           req_rdy,
  input logic [2*W-1:0] req_msg,
  input logic           resp_val,
  input logic           resp_rdy,
  input logic [W-1:0]   resp_data
);

  localparam int LW = $clog2(W + 3);
  localparam logic [LW-1:0] LAT = LW'(W + 1);

  logic [W-1:0]  cap_a, cap_b, cap_prod;
  logic [LW-1:0] busy_cnt;
  logic          accept;

  assign accept   = req_val && req_rdy;
  assign cap_prod = cap_a * cap_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
    end else if (accept) begin
      cap_a <= req_msg[2*W-1:W];
      cap_b <= req_msg[W-1:0];
    end
  end

  // cycles spent busy since the last accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            busy_cnt <= '0;
    else if (accept)                       busy_cnt <= '0;
    else if (!req_rdy && !resp_val &&
             busy_cnt != '1)               busy_cnt <= busy_cnt + LW'(1);
  end

  assert_excl_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rdy && resp_val));

  assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_val) |-> (resp_data == cap_prod));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_val) |-> (busy_cnt == LAT));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_val && !resp_rdy) |=> (resp_val && $stable(resp_data)));

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_rdy);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_val && resp_rdy) |=> (req_rdy && !resp_val));

endmodule

bind iter_mul iter_mul_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_val   (req_val),
  .req_rdy   (req_rdy),
  .req_msg   (req_msg),
  .resp_val  (resp_val),
  .resp_rdy  (resp_rdy),
  .resp_data (resp_data)
);

// File: tb/tb_iter_mul.sv
`timescale 1ns/1ps
module tb_iter_mul;

  localparam int W = 32;
  localparam int NV = 10;
  localparam int WATCHDOG_NS = 20 * 150000;

  // {A, B, expected low word}
  localparam logic [95:0] VECS [0:NV-1] = '{
    {32'h00000003, 32'h00000005, 32'h0000000F},
    {32'h00000007, 32'h00000006, 32'h0000002A},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001},
    {32'h00000000, 32'h12345678, 32'h00000000},
    {32'h12345678, 32'h00000001, 32'h12345678},
    {32'hFFFFFFFD, 32'h00000007, 32'hFFFFFFEB},
    {32'h80000000, 32'h00000002, 32'h00000000},
    {32'h00010000, 32'h00010000, 32'h00000000},
    {32'h0000FFFF, 32'h0000FFFF, 32'hFFFE0001},
    {32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFE}
  };

  logic           clk;
  logic           rst_n;
  logic           req_val;
  logic           req_rdy;
  logic [2*W-1:0] req_msg;
  logic           resp_val;
  logic           resp_rdy;
  logic [W-1:0]   resp_data;

  int n_chk;
  int n_bad;

  iter_mul #(.W(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_val   (req_val),
    .req_rdy   (req_rdy),
    .req_msg   (req_msg),
    .resp_val  (resp_val),
    .resp_rdy  (resp_rdy),
    .resp_data (resp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // One transaction; hold = cycles resp_rdy is withheld; poke = busy request
  task automatic run_txn(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] exp, input string tag,
                         input int hold, input bit poke);
    int edges;
    logic [W-1:0] first;
    @(negedge clk);
    check("R2 ready when idle", {31'd0, req_rdy}, 32'd1);
    req_val = 1'b1;
    req_msg = {a, b};
    @(posedge clk);
    #1;
    req_val = 1'b0;
    req_msg = '0;
    edges = 0;
    do begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (poke && edges == 5) begin
        check("R7 busy not ready", {31'd0, req_rdy}, 32'd0);
        req_val = 1'b1;
        req_msg = {32'h00000009, 32'h00000009};
      end
      if (poke && edges == 7) begin
        req_val = 1'b0;
        req_msg = '0;
      end
      if (!resp_val && edges < 40 && req_rdy)
        check("R2 ready while busy", {31'd0, req_rdy}, 32'd0);
    end while (!resp_val && edges < 60);
    check("R5 latency", W'(edges), W'(W + 1));
    check({tag, " product"}, resp_data, exp);
    first = resp_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R6 valid held", {31'd0, resp_val}, 32'd1);
      check("R6 data held", resp_data, first);
    end
    resp_rdy = 1'b1;
    @(posedge clk);
    #1;
    resp_rdy = 1'b0;
    @(negedge clk);
    check("R8 ready after handshake", {31'd0, req_rdy}, 32'd1);
    check("R8 valid dropped", {31'd0, resp_val}, 32'd0);
  endtask

  initial begin
    #(WATCHDOG_NS);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    req_val = 1'b0;
    req_msg = '0;
    resp_rdy = 1'b0;
    #5;
    check("R1 ready in reset", {31'd0, req_rdy}, 32'd1);
    check("R1 no result in reset", {31'd0, resp_val}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {31'd0, req_rdy}, 32'd1);

    // table walk; entry 3 follows a nonzero product (R9), 2 and 5 signed (R4)
    for (int i = 0; i < NV; i++) begin
      string t;
      if (i == 3)              t = "R9";
      else if (i == 2 || i == 5) t = "R4";
      else                     t = "R3";
      run_txn(VECS[i][95:64], VECS[i][63:32], VECS[i][31:0], t, i % 3, 1'b0);
    end

    // busy request must not disturb the result (R7)
    run_txn(32'h00001234, 32'h00000010, 32'h00012340, "R7", 2, 1'b1);
    // result after the poke must be that of a fresh request
    run_txn(32'h00000002, 32'h00000003, 32'h00000006, "R7 next", 0, 1'b0);

    // reset during a computation (R1)
    @(negedge clk);
    req_val = 1'b1;
    req_msg = {32'h00000005, 32'h00000005};
    @(posedge clk);
    #1;
    req_val = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 ready after mid reset", {31'd0, req_rdy}, 32'd1);
    check("R1 valid low after mid reset", {31'd0, resp_val}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_txn(32'h0000000B, 32'h0000000D, 32'h0000008F, "R9 after reset", 1, 1'b0);

    report();
  end

endmodule